// File: doc/BRIEF.md
# Input Select Decoder with Retained Hold Routing

This block turns a 3-bit input-select code into routing controls for a three-channel simultaneous-sampling front end. Channels 1 and 2 each pick one of five held sources: the asynchronous hold, sensor 2 through the main hold, sensor 2 through the auxiliary hold, sensor 1, or the phase current. Channel 3 picks one of four: auxiliary input 3, 2 or 1, or the phase current. The block also drives a capture enable for the two auxiliary simultaneous holds and a unity-gain flag for channel 3.

Two asynchronously controlled holds have a source selection that only codes 4, 5 and 6 change, on a frame-start strobe. Every other code keeps the last choice. The block also registers a per-frame flag. The flag tells downstream logic whether the asynchronous-hold values converted under code 1 can be trusted. The source must be non-open from an earlier frame, and the hold-control input must have been low in the cycle before the frame start.

Top module: `isel_decoder`

## Requirements
- R1: Code 7 sets chanOneSel and chanTwoSel to bit 4 (phase current) and chanThreeSel to bit 3 (phase current), with chanThreeUnity low.
- R2: Codes 4, 5 and 6 set chanOneSel and chanTwoSel to bit 3 (sensor 1) and chanThreeSel to bit 2 (auxiliary 1). auxHoldCapture is high for these three codes only.
- R3: On a clock edge with frameStart high and code 4, 5 or 6, asyncSrc becomes 2'b00 (open), 2'b01 (sensor 1) or 2'b10 (sensor 2) respectively, visible after that edge.
- R4: On a frame start with code 0, 1, 2, 3 or 7, asyncSrc keeps its previous value.
- R5: Code 3 sets chanOneSel and chanTwoSel to bit 2 (sensor 2 via auxiliary hold) and chanThreeSel to bit 1 (auxiliary 2).
- R6: Code 2 sets chanOneSel and chanTwoSel to bit 1 (sensor 2 via main hold) and chanThreeSel to bit 1 (auxiliary 2).
- R7: Code 1 sets chanOneSel and chanTwoSel to bit 0 (asynchronous hold). Code 0 sets them to all zero. Both codes set chanThreeSel to bit 0 (auxiliary 3).
- R8: chanThreeUnity is high exactly when chanThreeSel selects an auxiliary input (bits 0 to 2).
- R9: After reset, asyncSrc is 2'b00 and asyncValid is 0.
- R10: At each frame start, asyncValid is loaded with 1 only if the code is 1, asyncSrc before that edge is non-zero, and holdCtl was low in the cycle before the edge. Otherwise it is loaded with 0.
- R11: Without frameStart, changes of selCode and holdCtl leave asyncSrc and asyncValid unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| selCode | input | 3 | active input-select code |
| frameStart | input | 1 | one-cycle conversion frame start strobe |
| holdCtl | input | 1 | asynchronous hold control, high tracks, low stores |
| chanOneSel | output | 5 | one-hot source select, channel 1 |
| chanTwoSel | output | 5 | one-hot source select, channel 2 |
| chanThreeSel | output | 4 | one-hot source select, channel 3 |
| chanThreeUnity | output | 1 | channel 3 bypasses programmable gain |
| auxHoldCapture | output | 1 | auxiliary simultaneous holds capture sensor 2 |
| asyncSrc | output | 2 | retained asynchronous-hold source |
| asyncValid | output | 1 | asynchronous-hold data valid for this frame |

## Verification
A corrupted retained source shows up on asyncSrc right after the frame start that loads it. It also shows up one or more frames later, when a code-1 frame raises or withholds asyncValid wrongly. Code 1 is the only code that exposes the retained state through the valid flag, so the sweeps put every code before a code-1 frame, with both hold-control levels. A mis-sampled hold control affects only the frame that follows. It is caught by placing the low level either one cycle early or only on the strobe cycle.

// File: rtl/isd_pkg.sv
package isd_pkg;
  localparam int SEL_W    = 3;
  localparam int PAIR_SRC = 5;
  localparam int CH3_SRC  = 4;
  localparam int ASRC_W   = 2;

  typedef struct packed {
    logic             frameEdge;
    logic             loadSrc;
    logic [ASRC_W-1:0] newSrc;
    logic             wantValid;
  } isdStrobe_t;
endpackage

// File: rtl/isd_ctrl.sv
module isd_ctrl
  import isd_pkg::*;
(
  input  logic [SEL_W-1:0]    selCode,
  input  logic                frameStart,
  output logic [PAIR_SRC-1:0] pairSel,
  output logic [CH3_SRC-1:0]  ch3Sel,
  output logic                auxCapture,
  output isdStrobe_t          strobe
);
  logic senseOneCode;

  always_comb begin
    pairSel = '0;
    ch3Sel  = '0;
    case (selCode)
      3'd0: ch3Sel[0] = 1'b1;
      3'd1: begin pairSel[0] = 1'b1; ch3Sel[0] = 1'b1; end
      3'd2: begin pairSel[1] = 1'b1; ch3Sel[1] = 1'b1; end
      3'd3: begin pairSel[2] = 1'b1; ch3Sel[1] = 1'b1; end
      3'd7: begin pairSel[4] = 1'b1; ch3Sel[3] = 1'b1; end
      default: begin pairSel[3] = 1'b1; ch3Sel[2] = 1'b1; end
    endcase
  end

  assign senseOneCode = (selCode == 3'd4) || (selCode == 3'd5) || (selCode == 3'd6);
  assign auxCapture   = senseOneCode;

  always_comb begin
    strobe.frameEdge = frameStart;
    strobe.loadSrc   = frameStart && senseOneCode;
    strobe.wantValid = (selCode == 3'd1);
    case (selCode)
      3'd5:    strobe.newSrc = 2'b01;
      3'd6:    strobe.newSrc = 2'b10;
      default: strobe.newSrc = 2'b00;
    endcase
  end
endmodule

// File: rtl/isd_state.sv
module isd_state
  import isd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdCtl,
  input  isdStrobe_t        strobe,
  output logic [ASRC_W-1:0] srcQ,
  output logic              validQ
);
  logic holdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ   <= '0;
      validQ <= 1'b0;
      holdQ  <= 1'b1;
    end else begin
      holdQ <= holdCtl;
      if (strobe.loadSrc) srcQ <= strobe.newSrc;
      if (strobe.frameEdge)
        validQ <= strobe.wantValid && (srcQ != '0) && !holdQ;
    end
  end
endmodule

// File: rtl/isel_decoder.sv
module isel_decoder
  import isd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEL_W-1:0]    selCode,
  input  logic                frameStart,
  input  logic                holdCtl,
  output logic [PAIR_SRC-1:0] chanOneSel,
  output logic [PAIR_SRC-1:0] chanTwoSel,
  output logic [CH3_SRC-1:0]  chanThreeSel,
  output logic                chanThreeUnity,
  output logic                auxHoldCapture,
  output logic [ASRC_W-1:0]   asyncSrc,
  output logic                asyncValid
);
  isdStrobe_t          strobe;
  logic [PAIR_SRC-1:0] pairSel;

  isd_ctrl uCtrl (
    .selCode(selCode), .frameStart(frameStart), .pairSel(pairSel),
    .ch3Sel(chanThreeSel), .auxCapture(auxHoldCapture), .strobe(strobe)
  );

  isd_state uState (
    .clk(clk), .rstN(rstN), .holdCtl(holdCtl), .strobe(strobe),
    .srcQ(asyncSrc), .validQ(asyncValid)
  );

  assign chanOneSel     = pairSel;
  assign chanTwoSel     = pairSel;
  assign chanThreeUnity = !chanThreeSel[CH3_SRC-1];
endmodule

// File: rtl/isel_decoder_chk.sv
module isel_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] selCode,
  input logic       frameStart,
  input logic [4:0] chanOneSel,
  input logic [3:0] chanThreeSel,
  input logic       chanThreeUnity,
  input logic [1:0] asyncSrc,
  input logic       asyncValid
);
  a_r3_load_sensor1: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && selCode == 3'd5) |=> (asyncSrc == 2'b01));
  a_r3_load_sensor2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && selCode == 3'd6) |=> (asyncSrc == 2'b10));
  a_r4_src_kept: assert property (@(posedge clk) disable iff (!rstN)
    !(frameStart && (selCode == 3'd4 || selCode == 3'd5 || selCode == 3'd6)) |=> $stable(asyncSrc));
  a_r11_valid_kept: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(asyncValid));
  a_r10_needs_src: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && asyncSrc == 2'b00) |=> !asyncValid);
  a_r7_onehot_pair: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanOneSel) && $onehot0(asyncSrc));
  a_r8_unity_ch3: assert property (@(posedge clk) disable iff (!rstN)
    (chanThreeSel[3] |-> !chanThreeUnity) and ($countones(chanThreeSel) == 1));
endmodule

bind isel_decoder isel_decoder_chk uChk (
  .clk(clk), .rstN(rstN), .selCode(selCode), .frameStart(frameStart),
  .chanOneSel(chanOneSel), .chanThreeSel(chanThreeSel),
  .chanThreeUnity(chanThreeUnity), .asyncSrc(asyncSrc), .asyncValid(asyncValid)
);

// File: tb/tb_isel_decoder.sv
module tb_isel_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] selCode = 3'd0;
  logic frameStart = 1'b0;
  logic holdCtl = 1'b1;
  logic [4:0] chanOneSel, chanTwoSel;
  logic [3:0] chanThreeSel;
  logic chanThreeUnity, auxHoldCapture, asyncValid;
  logic [1:0] asyncSrc;
  int total = 0;
  int bad = 0;
  logic [1:0] mSrc;
  logic mValid;

  always #5 clk = ~clk;

  isel_decoder dut (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expPair(input int c);
    case (c)
      0: return 5'b00000;
      1: return 5'b00001;
      2: return 5'b00010;
      3: return 5'b00100;
      7: return 5'b10000;
      default: return 5'b01000;
    endcase
  endfunction

  function automatic logic [3:0] expCh3(input int c);
    case (c)
      0, 1: return 4'b0001;
      2, 3: return 4'b0010;
      7: return 4'b1000;
      default: return 4'b0100;
    endcase
  endfunction

  // one frame: hold level set a cycle ahead, strobe for one cycle
  task automatic frame(input int c, input logic h, input logic lateLow);
    logic [1:0] prevSrc;
    @(negedge clk);
    selCode = c[2:0];
    holdCtl = lateLow ? 1'b1 : h;
    @(negedge clk);
    frameStart = 1'b1;
    if (lateLow) holdCtl = 1'b0;
    @(negedge clk);
    frameStart = 1'b0;
    prevSrc = mSrc;
    if (c == 4) mSrc = 2'b00;
    if (c == 5) mSrc = 2'b01;
    if (c == 6) mSrc = 2'b10;
    mValid = (c == 1) && (prevSrc != 2'b00) && !(lateLow ? 1'b1 : h);
    check((c >= 4 && c <= 6) ? "R3" : "R4", asyncSrc, mSrc);
    check("R10", asyncValid, mValid);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mSrc = 2'b00;
    mValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", asyncSrc, 0);
    check("R9", asyncValid, 0);

    // combinational decode sweep
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      selCode = c[2:0];
      #1;
      check(c == 7 ? "R1" : (c >= 4 ? "R2" : (c == 3 ? "R5" : (c == 2 ? "R6" : "R7"))),
            chanOneSel, expPair(c));
      check("R7", chanTwoSel, expPair(c));
      check("R5", chanThreeSel, expCh3(c));
      check("R8", chanThreeUnity, (c != 7));
      check("R2", auxHoldCapture, (c >= 4 && c <= 6));
      check("R11", asyncSrc, 0);
    end

    // code 1 with open source, then every code/hold pair in turn
    frame(1, 1'b0, 1'b0);
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 8; c++)
        for (int h = 0; h < 2; h++) begin
          frame(c, h[0], 1'b0);
          frame(1, (c + h + r) % 2 == 0, 1'b0);
        end

    // hold goes low only on the strobe cycle: too late
    frame(6, 1'b0, 1'b0);
    frame(1, 1'b0, 1'b1);
    frame(1, 1'b0, 1'b0);
    check("R10", asyncValid, 1);

    // no strobe: code and hold wiggling changes nothing
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      selCode = c[2:0];
      holdCtl = c[0];
      @(negedge clk);
      check("R11", asyncSrc, mSrc);
      check("R11", asyncValid, mValid);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule